// File: doc/BRIEF.md
# Parallel Tree Summation Engine

This block adds up to N signed words held in a local register array by folding them pairwise along a binary tree. Software or an upstream block first fills the array one word per cycle through a simple load port. It then pulses a start strobe together with an element count n. The engine performs ceil(log2 n) combining rounds, one per clock. In each round a bank of N/2 adders works in parallel and writes its results back into the same array.

In round j, the adder that owns slot 2i adds the word that sits 2^j slots above it, if that word lies inside the first n slots. Slots without a partner keep their value. After the last round the total sits in slot 0. Slot 0 is always visible on the sum output, and a one-cycle done pulse marks completion. The total stays on the output until the array is written again.

Top module: `tree_red_engine`

## Requirements
- R1: After reset, busy and done are low and every array slot reads zero, so the sum output is 0.
- R2: A load (ld_valid_i high) writes ld_data_i into slot ld_idx_i. It takes effect only in a cycle where no reduction step runs, which means the engine is idle and start_i is low.
- R3: When start_i is accepted with count n, done_o pulses exactly max(ceil(log2 n), 1) clock cycles after the cycle in which start_i was high, measured on the same clock phase.
- R4: At done, the sum output equals the sum of slots 0 to n-1, taken modulo 2^W.
- R5: In round j, slot 2i takes slot 2i plus slot 2i+2^j only when i is a multiple of 2^j and 2i+2^j < n. Every other slot keeps its value, so slots at index n and above are never changed by a reduction. For the ten inputs 4 3 8 2 9 1 0 5 6 3 the result is 41.
- R6: A count of 0 or 1 changes no slot, and done follows start on the next cycle.
- R7: A count larger than N is treated as N.
- R8: Sums wrap modulo 2^W without saturation. Sixteen words of 16'h7FFF give 16'hFFF0.
- R9: A start pulse seen while busy_o is high is ignored and does not change the latency or the result.
- R10: Loads presented while busy_o is high are dropped.
- R11: busy_o rises only after an accepted start, and busy_o and done_o are never high together.
- R12: While idle with neither start nor load present, the sum output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | Write strobe for one array slot |
| ld_idx_i | input | $clog2(N) | Slot index for the write |
| ld_data_i | input | W | Word to write |
| start_i | input | 1 | Start a reduction, single-cycle pulse |
| count_i | input | $clog2(N+1) | Number of leading slots to sum |
| busy_o | output | 1 | Reduction rounds still pending |
| done_o | output | 1 | One-cycle completion strobe |
| sum_o | output | W | Current content of slot 0 |

## Verification
The hardest behaviour to reach is the reduction's in-place side effect on slots other than slot 0. Only slot 0 is visible at the ports. To expose the other slots, the bench runs a short reduction over a prefix of the array and then a full-width reduction. A bench model follows the same pairing rule, and a slot that was combined, skipped or corrupted in the first pass shows up as a wrong total in the second. Start and load pulses injected in the cycle right after an accepted start reach the window in which the engine must ignore them.

// File: rtl/tree_red_pkg.sv
package tree_red_pkg;

    localparam int RND_W = 5;
    localparam int CNT_W = 16;

    typedef logic [RND_W-1:0] rnd_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    // one combining step presented to the adder bank
    typedef struct packed {
        logic fire;
        rnd_t rnd;
        cnt_t cnt;
    } step_t;

    // ceil(log2(n)) for n >= 1
    function automatic int rounds_for(int n);
        int r;
        r = 0;
        for (int k = 0; k < 31; k++) begin
            if ((1 << r) < n) r = r + 1;
        end
        return r;
    endfunction

    // zero behaves like one, oversize counts saturate at the array size
    function automatic cnt_t clamp_count(int raw, int cap);
        if (raw < 1) return cnt_t'(1);
        if (raw > cap) return cnt_t'(cap);
        return cnt_t'(raw);
    endfunction

endpackage

// File: rtl/tree_red_ctrl.sv
module tree_red_ctrl
    import tree_red_pkg::*;
#(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    output step_t         step_o,
    output logic          busy_o,
    output logic          done_o
);

    state_e st_q;
    rnd_t   rnd_q;
    rnd_t   last_q;
    cnt_t   cnt_q;
    logic   done_q;

    cnt_t   cnt_eff;
    rnd_t   rnd_total;
    logic   accept;

    always_comb begin
        cnt_eff   = clamp_count(int'(count_i), N);
        rnd_total = rnd_t'(rounds_for(int'(cnt_eff)));
        accept    = (st_q == ST_IDLE) && start_i;
    end

    // round 0 runs on the accepting edge itself, later rounds from the counter
    always_comb begin
        step_o.fire = accept || (st_q == ST_RUN);
        step_o.rnd  = (st_q == ST_RUN) ? rnd_q : '0;
        step_o.cnt  = (st_q == ST_RUN) ? cnt_q : cnt_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rnd_q  <= '0;
            last_q <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (rnd_total <= rnd_t'(1)) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q   <= ST_RUN;
                            rnd_q  <= rnd_t'(1);
                            last_q <= rnd_total - rnd_t'(1);
                            cnt_q  <= cnt_eff;
                        end
                    end
                end
                ST_RUN: begin
                    if (rnd_q == last_q) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        rnd_q <= rnd_q + rnd_t'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q == ST_RUN);
    assign done_o = done_q;

endmodule

// File: rtl/tree_red_lanes.sv
module tree_red_lanes
    import tree_red_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 16
) (
    input  step_t          step_i,
    input  logic [N*W-1:0] cur_i,
    output logic [N*W-1:0] nxt_o
);

    localparam int LANES = N / 2;
    localparam int RMAX  = $clog2(N);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic [W-1:0] cand_val [RMAX];
        logic         cand_ok  [RMAX];
        cnt_t         cand_idx [RMAX];
        logic [W-1:0] own;
        logic [W-1:0] partner;
        logic         pair_ok;
        cnt_t         pair_idx;
        logic         on;
        logic [W-1:0] lane_sum;

        // static partner wiring for every round this lane can take part in
        for (genvar gr = 0; gr < RMAX; gr++) begin : g_rnd
            if (((gi % (1 << gr)) == 0) && ((2 * gi + (1 << gr)) < N)) begin : g_pair
                assign cand_val[gr] = cur_i[(2 * gi + (1 << gr)) * W +: W];
                assign cand_ok[gr]  = 1'b1;
                assign cand_idx[gr] = cnt_t'(2 * gi + (1 << gr));
            end else begin : g_none
                assign cand_val[gr] = '0;
                assign cand_ok[gr]  = 1'b0;
                assign cand_idx[gr] = '0;
            end
        end

        always_comb begin
            own      = cur_i[2 * gi * W +: W];
            partner  = '0;
            pair_ok  = 1'b0;
            pair_idx = '0;
            for (int r = 0; r < RMAX; r++) begin
                if (step_i.rnd == rnd_t'(r)) begin
                    partner  = cand_val[r];
                    pair_ok  = cand_ok[r];
                    pair_idx = cand_idx[r];
                end
            end
            on       = step_i.fire && pair_ok && (pair_idx < step_i.cnt);
            lane_sum = own + partner;
        end

        assign nxt_o[2 * gi * W +: W]       = on ? lane_sum : own;
        assign nxt_o[(2 * gi + 1) * W +: W] = cur_i[(2 * gi + 1) * W +: W];
    end

endmodule

// File: rtl/tree_red_regs.sv
module tree_red_regs #(
    parameter int N  = 16,
    parameter int W  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld_en_i,
    input  logic [IW-1:0]  ld_idx_i,
    input  logic [W-1:0]   ld_data_i,
    input  logic           upd_en_i,
    input  logic [N*W-1:0] upd_data_i,
    output logic [N*W-1:0] q_o
);

    logic [W-1:0] slot_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) slot_q[k] <= '0;
        end else if (upd_en_i) begin
            for (int k = 0; k < N; k++) slot_q[k] <= upd_data_i[k * W +: W];
        end else if (ld_en_i) begin
            for (int k = 0; k < N; k++) begin
                if (ld_idx_i == IW'(k)) slot_q[k] <= ld_data_i;
            end
        end
    end

    for (genvar gk = 0; gk < N; gk++) begin : g_out
        assign q_o[gk * W +: W] = slot_q[gk];
    end

endmodule

// File: rtl/tree_red_engine.sv
module tree_red_engine
    import tree_red_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 16,
    localparam int IW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_valid_i,
    input  logic [IW-1:0] ld_idx_i,
    input  logic [W-1:0]  ld_data_i,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  sum_o
);

    step_t          step;
    logic [N*W-1:0] cur;
    logic [N*W-1:0] nxt;
    logic           ld_en;

    tree_red_ctrl #(.N(N), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .count_i (count_i),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    tree_red_lanes #(.N(N), .W(W)) u_lanes (
        .step_i (step),
        .cur_i  (cur),
        .nxt_o  (nxt)
    );

    // a running step owns the array; loads only land on quiet cycles
    assign ld_en = ld_valid_i && !step.fire;

    tree_red_regs #(.N(N), .W(W), .IW(IW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ld_en_i    (ld_en),
        .ld_idx_i   (ld_idx_i),
        .ld_data_i  (ld_data_i),
        .upd_en_i   (step.fire),
        .upd_data_i (nxt),
        .q_o        (cur)
    );

    assign sum_o = cur[W-1:0];

endmodule

// File: rtl/tree_red_chk.sv
module tree_red_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         ld_valid_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] sum_o
);

    // R1: reset clears the control state and slot 0
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && (sum_o == '0)));

    // R11: running and finishing are exclusive
    a_r11_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    // R11: busy is only entered from an accepted start
    a_r11_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R3: leaving the running state is always the completion cycle
    a_r3_fall_is_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R12: an idle engine with no stimulus keeps its total
    a_r12_hold_total: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i && !ld_valid_i) |=> $stable(sum_o));

endmodule

bind tree_red_engine tree_red_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ld_valid_i (ld_valid_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sum_o      (sum_o)
);

// File: tb/tree_red_engine_bench.sv
module tree_red_engine_bench;

    localparam int N  = 16;
    localparam int W  = 16;
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_valid_i = 1'b0;
    logic [IW-1:0] ld_idx_i = '0;
    logic [W-1:0]  ld_data_i = '0;
    logic          start_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [W-1:0]  sum_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [W-1:0] model [N];

    always #5 clk = ~clk;

    tree_red_engine #(.N(N), .W(W)) u_tree_red_engine (
        .clk        (clk),
        .rst        (rst),
        .ld_valid_i (ld_valid_i),
        .ld_idx_i   (ld_idx_i),
        .ld_data_i  (ld_data_i),
        .start_i    (start_i),
        .count_i    (count_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .sum_o      (sum_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_count(int n);
        if (n < 1) return 1;
        if (n > N) return N;
        return n;
    endfunction

    function automatic int ceil_log2(int n);
        int r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    // pairing rule of R5 applied to the bench copy of the array
    task automatic model_reduce(input int n);
        int e = eff_count(n);
        for (int j = 0; (1 << j) < e; j++) begin
            for (int i = 0; i < N / 2; i++) begin
                if ((i % (1 << j)) == 0 && (2 * i + (1 << j)) < e)
                    model[2 * i] = model[2 * i] + model[2 * i + (1 << j)];
            end
        end
    endtask

    task automatic load_one(input int idx, input int val);
        @(negedge clk);
        ld_valid_i = 1'b1;
        ld_idx_i   = IW'(idx);
        ld_data_i  = W'(val);
        model[idx] = W'(val);
        @(negedge clk);
        ld_valid_i = 1'b0;
    endtask

    // start a reduction, optionally poke start/load one cycle later, check latency and total
    task automatic run_reduce(input int n, input string req, input bit inj_start, input bit inj_load);
        int lat;
        int exp_lat;
        exp_lat = ceil_log2(eff_count(n));
        if (exp_lat < 1) exp_lat = 1;
        @(negedge clk);
        start_i = 1'b1;
        count_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        if (inj_start) begin start_i = 1'b1; count_i = CW'(2); end
        if (inj_load) begin ld_valid_i = 1'b1; ld_idx_i = '0; ld_data_i = W'(999); end
        while (!done_o && lat < 64) begin
            @(negedge clk);
            start_i = 1'b0;
            ld_valid_i = 1'b0;
            lat++;
        end
        start_i = 1'b0;
        ld_valid_i = 1'b0;
        model_reduce(n);
        check(done_o == 1'b1, {req, " R3 done seen"}, done_o, 1);
        check(lat == exp_lat, {req, " R3 latency"}, lat, exp_lat);
        check(sum_o == model[0], {req, " R4 total"}, sum_o, model[0]);
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, {req, " R11 done is one pulse"}, done_o, 0);
    endtask

    task automatic t_reset;
        check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        check(done_o == 1'b0, "R1 done after reset", done_o, 0);
        check(sum_o == '0, "R1 sum after reset", sum_o, 0);
    endtask

    task automatic t_ten_example;
        int v [10] = '{4, 3, 8, 2, 9, 1, 0, 5, 6, 3};
        for (int k = 0; k < N; k++) load_one(k, (k < 10) ? v[k] : 100);
        run_reduce(10, "R5 ten-word example", 1'b0, 1'b0);
        check(sum_o == W'(41), "R5 literal total 41", sum_o, 41);
    endtask

    task automatic t_full_width;
        for (int k = 0; k < N; k++) load_one(k, k * 37 - 200);
        run_reduce(N, "R4 full array", 1'b0, 1'b0);
    endtask

    task automatic t_prefix_then_full;
        for (int k = 0; k < N; k++) load_one(k, k + 1);
        run_reduce(5, "R5 prefix of five", 1'b0, 1'b0);
        check(sum_o == W'(15), "R5 prefix total", sum_o, 15);
        run_reduce(N, "R5 upper slots untouched", 1'b0, 1'b0);
    endtask

    task automatic t_small_counts;
        load_one(0, 77);
        load_one(1, 5);
        load_one(2, 6);
        run_reduce(1, "R6 count one", 1'b0, 1'b0);
        check(sum_o == W'(77), "R6 count one keeps slot 0", sum_o, 77);
        run_reduce(0, "R6 count zero", 1'b0, 1'b0);
        check(sum_o == W'(77), "R6 count zero keeps slot 0", sum_o, 77);
        run_reduce(2, "R3 count two", 1'b0, 1'b0);
        check(sum_o == W'(82), "R3 count two total", sum_o, 82);
        run_reduce(3, "R3 count three", 1'b0, 1'b0);
    endtask

    task automatic t_clamp;
        for (int k = 0; k < N; k++) load_one(k, 3 * k + 1);
        run_reduce(20, "R7 oversize count", 1'b0, 1'b0);
    endtask

    task automatic t_wrap;
        for (int k = 0; k < N; k++) load_one(k, 'h7FFF);
        run_reduce(N, "R8 wrap", 1'b0, 1'b0);
        check(sum_o == W'('hFFF0), "R8 wrapped literal", sum_o, 'hFFF0);
    endtask

    task automatic t_busy_start;
        for (int k = 0; k < N; k++) load_one(k, 2 * k + 3);
        run_reduce(N, "R9 start while busy", 1'b1, 1'b0);
    endtask

    task automatic t_busy_load;
        logic [W-1:0] keep;
        for (int k = 0; k < N; k++) load_one(k, 5 * k - 9);
        run_reduce(N, "R10 load while busy", 1'b0, 1'b1);
        keep = sum_o;
        run_reduce(1, "R10 slot 0 after dropped load", 1'b0, 1'b0);
        check(sum_o == keep, "R10 dropped load left slot 0", sum_o, keep);
    endtask

    task automatic t_hold;
        logic [W-1:0] keep;
        keep = sum_o;
        repeat (6) @(negedge clk);
        check(sum_o == keep, "R12 idle hold", sum_o, keep);
        load_one(0, 1234);
        check(sum_o == W'(1234), "R2 load reaches slot 0", sum_o, 1234);
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ten_example();
        t_full_width();
        t_prefix_then_full();
        t_small_counts();
        t_clamp();
        t_wrap();
        t_busy_start();
        t_busy_load();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule